// File: doc/BRIEF.md
# Standby Wake-Up Sequencing Controller

This block governs the low-power standby state of a processor. Software arms standby by setting a standby bit through a small register port and then raises a sleep request. The block then gates the chip clock off and drives both status pins high. Any of several wake sources ends standby: a non-maskable interrupt, an external interrupt line, a level-encoded prioritised request that beats the current mask level, a port interrupt, a peripheral interrupt other than the watchdog's own interval timer, or the asynchronous reset.

Once a wake interrupt is seen, the clock is not restored at once. An 8-bit settling counter, advanced by a prescaler, must wrap from all-ones to zero to cover oscillator and PLL settling. Only then does the clock enable return. At that point the status pins drop, a one-cycle interrupt-taken pulse is issued, and a code naming the winning source is held. After waking, the counter keeps running. If software has not cleared the standby bit by the time the counter reaches its midpoint value, the block drops back into standby. Clearing the bit stops the counter and leaves the chip running.

Top module: `standby_wake_ctrl`

## Requirements
- R1: While running with the standby bit set (register select 0, data bit 0), a sleep request turns the clock enable off and drives status to 2'b11 from the next cycle. With the bit clear, a sleep request has no effect.
- R2: In standby, any of these starts settling: the non-maskable interrupt, any external interrupt bit, any port interrupt bit, any peripheral bit other than the excluded one, or a qualifying level request.
- R3: A level request wakes only when its 4-bit level is strictly greater than the 4-bit mask level. An equal or lower level leaves the block in standby.
- R4: The settling counter advances once every 2^sel cycles, where sel is written through register select 1, data bits [2:0]. The clock enable stays low until the counter wraps from 0xFF to 0x00, which happens exactly 256*2^sel cycles after the edge that samples the wake.
- R5: When the clock enable returns, status reads 2'b00 and the interrupt-taken pulse is high for exactly that one cycle. The source code is then NMI=1, level=2, external=3, port=4, peripheral=5, with priority in that order when sources coincide.
- R6: Wake requests arriving during settling are ignored. They change neither the source code nor the restore time.
- R7: Writing the standby bit to 0 after waking stops the counter, and the block stays running.
- R8: If the standby bit is still set, standby is re-entered (clock enable low, status 2'b11) 128*2^sel cycles after the clock returns, when the counter reaches 0x80.
- R9: Reset, including a reset during settling, forces clock enable 1, status 2'b00, the pulse low and source code 0, and clears the standby bit.
- R10: Peripheral bit ITMR_IDX (default 0), the watchdog interval timer, never wakes the block.
- R11: Wake inputs seen while running leave the source code unchanged and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset; also a wake source |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 standby bit, 1 prescaler select |
| cfg_wdata | input | SEL_W | Write data |
| sleep_req | input | 1 | Sleep instruction pulse |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | N_IRQ | External interrupt lines |
| irl_lvl | input | LVL_W | Level-encoded request, 0 = none |
| mask_lvl | input | LVL_W | Current interrupt mask level |
| port_int | input | N_PORT | Port interrupts |
| periph_int | input | N_PER | Peripheral interrupts |
| clk_en | output | 1 | Chip clock enable |
| status | output | 2 | 2'b11 in standby and settling, 2'b00 otherwise |
| int_take | output | 1 | One-cycle pulse when a wake interrupt is taken |
| src_code | output | 3 | Code of the last wake source |

## Verification
Entering standby shows one cycle after the sleep request edge. The clock returns, together with the pulse and the code, exactly 256*2^sel edges after the wake is sampled. Re-entry follows 128*2^sel edges after that. The bench drives inputs just after a falling edge and samples outputs on falling edges. Around each restore and re-entry it checks the cycle just before the due edge (still off or still on) and the cycle at the due edge, so an early or late result by one cycle is caught. Cases that must be ignored are held for longer than a full settling interval before the outputs are checked.

// File: rtl/swk_pkg.sv
`timescale 1ns/1ps
package swk_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STBY   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_AWAKE  = 2'd3
    } swk_state_e;

    localparam logic [2:0] SRC_NONE  = 3'd0;
    localparam logic [2:0] SRC_NMI   = 3'd1;
    localparam logic [2:0] SRC_LVL   = 3'd2;
    localparam logic [2:0] SRC_EXT   = 3'd3;
    localparam logic [2:0] SRC_PORT  = 3'd4;
    localparam logic [2:0] SRC_PERIPH = 3'd5;
endpackage

// File: rtl/swk_wake_detect.sv
`timescale 1ns/1ps
module swk_wake_detect
    import swk_pkg::*;
#(
    parameter int N_IRQ    = 6,
    parameter int N_PORT   = 2,
    parameter int N_PER    = 8,
    parameter int LVL_W    = 4,
    parameter int ITMR_IDX = 0
) (
    input  logic              nmi,
    input  logic [N_IRQ-1:0]  irq,
    input  logic [LVL_W-1:0]  irl_lvl,
    input  logic [LVL_W-1:0]  mask_lvl,
    input  logic [N_PORT-1:0] port_int,
    input  logic [N_PER-1:0]  periph_int,
    output logic              wake,
    output logic [2:0]        code
);
    localparam logic [N_PER-1:0] PER_KEEP = ~(N_PER'(1) << ITMR_IDX);

    logic lvl_hit;
    logic per_hit;

    always_comb begin
        lvl_hit = (irl_lvl > mask_lvl);
        per_hit = |(periph_int & PER_KEEP);
        if (nmi)                 code = SRC_NMI;
        else if (lvl_hit)        code = SRC_LVL;
        else if (|irq)           code = SRC_EXT;
        else if (|port_int)      code = SRC_PORT;
        else if (per_hit)        code = SRC_PERIPH;
        else                     code = SRC_NONE;
        wake = (code != SRC_NONE);
    end
endmodule

// File: rtl/swk_prescale.sv
`timescale 1ns/1ps
module swk_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            lim[i] = (i < int'(sel));
        end
        tick  = run && (pre_q == lim);
        pre_d = pre_q;
        if (!run)      pre_d = '0;
        else if (tick) pre_d = '0;
        else           pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/standby_wake_ctrl.sv
`timescale 1ns/1ps
module standby_wake_ctrl
    import swk_pkg::*;
#(
    parameter int N_IRQ    = 6,
    parameter int N_PORT   = 2,
    parameter int N_PER    = 8,
    parameter int LVL_W    = 4,
    parameter int ITMR_IDX = 0,
    parameter int CNT_W    = 8,
    parameter int SEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_addr,
    input  logic [SEL_W-1:0]  cfg_wdata,
    input  logic              sleep_req,
    input  logic              nmi,
    input  logic [N_IRQ-1:0]  irq,
    input  logic [LVL_W-1:0]  irl_lvl,
    input  logic [LVL_W-1:0]  mask_lvl,
    input  logic [N_PORT-1:0] port_int,
    input  logic [N_PER-1:0]  periph_int,
    output logic              clk_en,
    output logic [1:0]        status,
    output logic              int_take,
    output logic [2:0]        src_code
);
    localparam logic [CNT_W-1:0] CNT_TOP  = '1;
    localparam logic [CNT_W-1:0] RET_LAST = (CNT_W'(1) << (CNT_W - 1)) - 1'b1;

    typedef struct packed {
        swk_state_e       st;
        logic             stby;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       code;
        logic             take;
    } swk_regs_t;

    swk_regs_t r_d, r_q;

    logic       wake;
    logic [2:0] wake_code;
    logic       tick;
    logic       cnt_run;

    swk_wake_detect #(
        .N_IRQ(N_IRQ), .N_PORT(N_PORT), .N_PER(N_PER),
        .LVL_W(LVL_W), .ITMR_IDX(ITMR_IDX)
    ) u_detect (
        .nmi(nmi), .irq(irq), .irl_lvl(irl_lvl), .mask_lvl(mask_lvl),
        .port_int(port_int), .periph_int(periph_int),
        .wake(wake), .code(wake_code)
    );

    assign cnt_run = (r_q.st == ST_SETTLE) || (r_q.st == ST_AWAKE);

    swk_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(cnt_run), .sel(r_q.sel), .tick(tick)
    );

    always_comb begin
        r_d      = r_q;
        r_d.take = 1'b0;
        if (cfg_we) begin
            if (cfg_addr == 1'b0) r_d.stby = cfg_wdata[0];
            else                  r_d.sel  = cfg_wdata;
        end
        unique case (r_q.st)
            ST_RUN: begin
                if (sleep_req && r_q.stby) begin
                    r_d.st  = ST_STBY;
                    r_d.cnt = '0;
                end
            end
            ST_STBY: begin
                if (wake) begin
                    r_d.st   = ST_SETTLE;
                    r_d.cnt  = '0;
                    r_d.code = wake_code;
                end
            end
            ST_SETTLE: begin
                if (tick) begin
                    if (r_q.cnt == CNT_TOP) begin
                        r_d.cnt  = '0;
                        r_d.st   = ST_AWAKE;
                        r_d.take = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            ST_AWAKE: begin
                if (!r_d.stby) begin
                    r_d.st = ST_RUN;
                end else if (tick) begin
                    if (r_q.cnt == RET_LAST) begin
                        r_d.st  = ST_STBY;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_RUN;
            r_q.stby <= 1'b0;
            r_q.sel  <= '0;
            r_q.cnt  <= '0;
            r_q.code <= SRC_NONE;
            r_q.take <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_en   = (r_q.st == ST_RUN) || (r_q.st == ST_AWAKE);
    assign status   = clk_en ? 2'b00 : 2'b11;
    assign int_take = r_q.take;
    assign src_code = r_q.code;
endmodule

// File: rtl/swk_checker.sv
`timescale 1ns/1ps
module swk_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       clk_en,
    input logic [1:0] status,
    input logic       int_take,
    input logic [2:0] src_code,
    input logic       stby_q
);
    // R5: the taken pulse lasts one cycle
    a_r5_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |=> !int_take);

    // R5: the pulse coincides with a running clock and low status
    a_r5_take_running: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> (clk_en && status == 2'b00));

    // R4: the clock only comes back through a taken wake interrupt
    a_r4_rise_takes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_en) |-> int_take);

    // R8 and R1: a clock drop always shows standby on the status pins
    a_r8_fall_standby: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en) |-> status == 2'b11);

    // R7: with the standby bit clear, a running clock stays on
    a_r7_clear_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !stby_q) |=> clk_en);

    // R11: the source code holds while the clock keeps running
    a_r11_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && $past(clk_en)) |-> $stable(src_code));
endmodule

bind standby_wake_ctrl swk_checker u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .status(status),
    .int_take(int_take), .src_code(src_code), .stby_q(r_q.stby)
);

// File: tb/sim_standby_wake_ctrl.sv
`timescale 1ns/1ps
module sim_standby_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [2:0] cfg_wdata = '0;
    logic       sleep_req = 1'b0;
    logic       nmi = 1'b0;
    logic [5:0] irq = '0;
    logic [3:0] irl_lvl = '0;
    logic [3:0] mask_lvl = '0;
    logic [1:0] port_int = '0;
    logic [7:0] periph_int = '0;
    logic       clk_en;
    logic [1:0] status;
    logic       int_take;
    logic [2:0] src_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    standby_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .sleep_req(sleep_req), .nmi(nmi), .irq(irq),
        .irl_lvl(irl_lvl), .mask_lvl(mask_lvl), .port_int(port_int),
        .periph_int(periph_int), .clk_en(clk_en), .status(status),
        .int_take(int_take), .src_code(src_code)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_code(logic n, logic [3:0] l, logic [3:0] m,
                                            logic [5:0] q, logic [1:0] p, logic [7:0] pe);
        if (n)                       return 3'd1;
        else if (l > m)              return 3'd2;
        else if (q != 0)             return 3'd3;
        else if (p != 0)             return 3'd4;
        else if ((pe & 8'hFE) != 0)  return 3'd5;
        else                         return 3'd0;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [2:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic enter_standby;
        wr(1'b0, 3'd1);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk("R1 clk_en off", 32'(clk_en), 0);
        chk("R1 status standby", 32'(status), 32'h3);
    endtask

    task automatic clear_wake;
        nmi = 0; irq = '0; irl_lvl = '0; port_int = '0; periph_int = '0;
    endtask

    // drives one wake pattern and checks settling timing and result
    task automatic wake_and_check(input int d, input logic n, input logic [3:0] l,
                                  input logic [3:0] m, input logic [5:0] q,
                                  input logic [1:0] p, input logic [7:0] pe,
                                  input bit inject, input int inj_at);
        logic [2:0] e;
        e = exp_code(n, l, m, q, p, pe);
        nmi = n; irl_lvl = l; mask_lvl = m; irq = q; port_int = p; periph_int = pe;
        @(negedge clk);
        clear_wake();
        if (inject) begin
            cyc(inj_at);
            nmi = 1'b1; irq = 6'h3F;
            @(negedge clk);
            clear_wake();
            cyc(256 * d - 2 - inj_at);
        end else begin
            cyc(256 * d - 1);
        end
        chk("R4 still settling", 32'(clk_en), 0);
        @(negedge clk);
        chk("R4 clock restored", 32'(clk_en), 1);
        chk("R5 status low", 32'(status), 0);
        chk("R5 pulse high", 32'(int_take), 1);
        chk(inject ? "R6 code kept" : "R5 source code", 32'(src_code), 32'(e));
        @(negedge clk);
        chk("R5 pulse one cycle", 32'(int_take), 0);
    endtask

    initial begin
        void'($urandom(32'd1357));
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R9 reset state
        chk("R9 clk_en", 32'(clk_en), 1);
        chk("R9 status", 32'(status), 0);
        chk("R9 pulse", 32'(int_take), 0);
        chk("R9 code", 32'(src_code), 0);

        // R1 sleep with bit clear
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        chk("R1 no entry bit clear", 32'(clk_en), 1);

        // R11 wake inputs while running
        nmi = 1'b1; @(negedge clk); nmi = 1'b0;
        chk("R11 no pulse", 32'(int_take), 0);
        chk("R11 code kept", 32'(src_code), 0);

        // R3 equal and lower levels, R10 interval timer bit
        wr(1'b1, 3'd0);
        enter_standby();
        irl_lvl = 4'd5; mask_lvl = 4'd5; cyc(300);
        chk("R3 equal level ignored", 32'(clk_en), 0);
        irl_lvl = 4'd2; cyc(300);
        chk("R3 lower level ignored", 32'(clk_en), 0);
        clear_wake();
        periph_int = 8'h01; cyc(300);
        chk("R10 timer bit ignored", 32'(clk_en), 0);
        clear_wake();

        // R2 level one above mask wakes, R8 re-entry with sel 0
        wake_and_check(1, 0, 4'd6, 4'd5, '0, '0, '0, 0, 0);
        cyc(128 - 2);
        chk("R8 before re-entry", 32'(clk_en), 1);
        @(negedge clk);
        chk("R8 re-entered clk", 32'(clk_en), 0);
        chk("R8 re-entered status", 32'(status), 32'h3);

        // R2 peripheral bit 7 wakes from re-entered standby, then R7 clear
        wake_and_check(1, 0, '0, '0, '0, '0, 8'h81, 0, 0);
        wr(1'b0, 3'd0);
        cyc(400);
        chk("R7 stays running", 32'(clk_en), 1);

        // R9 reset during settling
        enter_standby();
        nmi = 1'b1; @(negedge clk); nmi = 1'b0;
        cyc(50);
        rst_n = 1'b0; #1;
        chk("R9 reset clk_en", 32'(clk_en), 1);
        chk("R9 reset status", 32'(status), 0);
        chk("R9 reset code", 32'(src_code), 0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);
        sleep_req = 1'b1; @(negedge clk); sleep_req = 1'b0;
        chk("R9 standby bit cleared", 32'(clk_en), 1);

        // random trials
        for (int t = 0; t < 30; t++) begin
            int s;
            int d;
            logic n; logic [3:0] l; logic [3:0] m; logic [5:0] q;
            logic [1:0] p; logic [7:0] pe;
            bit inj;
            s = $urandom_range(0, 2);
            d = 1 << s;
            wr(1'b1, 3'(s));
            if (clk_en) enter_standby();
            do begin
                n  = ($urandom_range(0, 4) == 0);
                l  = 4'($urandom);
                m  = 4'($urandom);
                q  = ($urandom_range(0, 2) == 0) ? 6'($urandom) : '0;
                p  = ($urandom_range(0, 2) == 0) ? 2'($urandom) : '0;
                pe = ($urandom_range(0, 2) == 0) ? 8'($urandom) : '0;
            end while (exp_code(n, l, m, q, p, pe) == 3'd0);
            inj = ($urandom_range(0, 1) == 1);
            wake_and_check(d, n, l, m, q, p, pe, inj, $urandom_range(0, 256 * d - 3));
            if ($urandom_range(0, 1) == 1) begin
                cyc(128 * d - 2);
                chk("R8 before re-entry", 32'(clk_en), 1);
                @(negedge clk);
                chk("R8 re-entered", 32'(status), 32'h3);
            end else begin
                cyc($urandom_range(0, 128 * d - 3));
                wr(1'b0, 3'd0);
                cyc(128 * d + 8);
                chk("R7 cleared stays on", 32'(clk_en), 1);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        cyc(200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule